// File: doc/BRIEF.md
# Store Completion Tracker

A store instruction whose data spans several cache lines is issued to memory as several line requests. Each of those requests is acknowledged separately, but the requester wants only one answer for the whole instruction. This block keeps a small table keyed by instruction sequence number. Each entry holds the number of line requests that are still unacknowledged and the requester identity to return to.

A request-created event bumps the count and opens an entry when the sequence number is new. An acknowledgement lowers the count. When an acknowledgement brings the count to zero, the block asks the coalescer in the same cycle whether packets of that instruction are still waiting to be coalesced. Only if none are waiting does it emit one completion pulse with the sequence number and requester identity, and then it frees the entry. If packets are still waiting, the entry stays open. A later request for that instruction reopens the count, and the instruction completes on that request's acknowledgement.

Top module: `store_done_tracker`

## Requirements
- R1: After reset, `done_valid` and `err_sticky` are 0 and the table holds no live entries.
- R2: The first request for a sequence number opens an entry and captures `req_rid`. A `req_rid` that arrives with a later request for the same live sequence number is ignored, and the completion returns the first identity.
- R3: Each request adds one to the instruction's outstanding count and each acknowledgement removes one. Completion needs as many acknowledgements as requests.
- R4: An acknowledgement that brings the count to zero while `qry_pending` is 0 raises `done_valid` for exactly one cycle, starting the cycle after the acknowledgement. The pulse carries that `done_seq` and the captured `done_rid`, and the entry is freed, so a later request with the same number opens a fresh entry.
- R5: An acknowledgement that brings the count to zero while `qry_pending` is 1 gives no completion, and the entry stays live with its identity.
- R6: An acknowledgement whose sequence number has no live entry, or that would take a zero count below zero, sets `err_sticky`. It produces no completion, and `err_sticky` stays 1 until reset.
- R7: A request for a new sequence number while all `ENTRIES` entries are live is dropped and sets `err_sticky`.
- R8: `qry_valid` and `qry_seq` follow `ack_valid` and `ack_seq` in the same cycle.
- R9: A request and an acknowledgement for the same live sequence number in the same cycle leave its count unchanged and give no completion.
- R10: Completions for different instructions come out in acknowledgement order, at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A line request was created for a store |
| req_seq | input | SEQ_W | Sequence number of that store |
| req_rid | input | RID_W | Requester identity to return to |
| ack_valid | input | 1 | Write-complete acknowledgement |
| ack_seq | input | SEQ_W | Sequence number being acknowledged |
| qry_valid | output | 1 | Buffer query toward the coalescer |
| qry_seq | output | SEQ_W | Sequence number being queried |
| qry_pending | input | 1 | Coalescer still buffers packets for `qry_seq` |
| done_valid | output | 1 | One-cycle completion pulse |
| done_seq | output | SEQ_W | Completed sequence number |
| done_rid | output | RID_W | Requester identity of the completed store |
| err_sticky | output | 1 | Orphan acknowledgement, underflow or table overflow seen |

## Verification
On every cycle, the assertions check the following. A completion always follows an acknowledgement of the same sequence number in the previous cycle, and that acknowledgement saw an empty buffer. The error flag never falls. Orphan acknowledgements and requests dropped because the table is full raise the flag. An acknowledgement never matches more than one entry. Only the bench scenarios can show the counting itself: how many acknowledgements a store needs, that the first requester identity is kept, that an entry held back by a busy buffer completes later, and that a freed entry reopens under a new identity.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  // entry retires: the count falls to zero and the coalescer holds nothing more
  function automatic logic retire_cond(input logic dec, input logic inc,
                                       input logic cnt_one, input logic busy);
    return dec && !inc && cnt_one && !busy;
  endfunction

  // acknowledgement against an entry whose count is already zero
  function automatic logic under_cond(input logic dec, input logic inc,
                                      input logic cnt_zero);
    return dec && !inc && cnt_zero;
  endfunction

endpackage

// File: rtl/sdt_match.sv
module sdt_match #(
  parameter int N     = 4,
  parameter int SEQ_W = 16
) (
  input  logic [N-1:0]       live,
  input  logic [N*SEQ_W-1:0] seq_flat,
  input  logic [SEQ_W-1:0]   key,
  output logic [N-1:0]       hit_vec,
  output logic               hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = live[i] && (seq_flat[i*SEQ_W +: SEQ_W] == key);
  end
  assign hit = |hit_vec;
endmodule

// File: rtl/sdt_alloc.sv
module sdt_alloc #(
  parameter int N = 4
) (
  input  logic [N-1:0] live,
  output logic [N-1:0] pick,
  output logic         full
);
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      if (!live[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end
  assign full = &live;
endmodule

// File: rtl/store_done_tracker.sv
module store_done_tracker #(
  parameter int SEQ_W   = 16,
  parameter int RID_W   = 4,
  parameter int ENTRIES = 4,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic [RID_W-1:0] req_rid,
  input  logic             ack_valid,
  input  logic [SEQ_W-1:0] ack_seq,
  output logic             qry_valid,
  output logic [SEQ_W-1:0] qry_seq,
  input  logic             qry_pending,
  output logic             done_valid,
  output logic [SEQ_W-1:0] done_seq,
  output logic [RID_W-1:0] done_rid,
  output logic             err_sticky
);
  import sdt_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic inc, input logic dec);
    case ({inc, dec})
      2'b10:   return c + CNT_ONE;
      2'b01:   return c - CNT_ONE;
      default: return c;
    endcase
  endfunction

  logic [ENTRIES-1:0]       live_q;
  logic [ENTRIES*SEQ_W-1:0] seq_q;
  logic [CNT_W-1:0]         cnt_q [ENTRIES];
  logic [RID_W-1:0]         rid_q [ENTRIES];

  // named internal events
  logic [ENTRIES-1:0] req_hit_vec, ack_hit_vec, alloc_vec;
  logic [ENTRIES-1:0] inc_vec, dec_vec, fin_vec, under_vec;
  logic               req_hit, ack_hit, tbl_full, req_new, req_drop, ack_orphan;
  logic [RID_W-1:0]   fin_rid;

  sdt_match #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_req_match (
    .live(live_q), .seq_flat(seq_q), .key(req_seq),
    .hit_vec(req_hit_vec), .hit(req_hit));

  sdt_match #(.N(ENTRIES), .SEQ_W(SEQ_W)) u_ack_match (
    .live(live_q), .seq_flat(seq_q), .key(ack_seq),
    .hit_vec(ack_hit_vec), .hit(ack_hit));

  sdt_alloc #(.N(ENTRIES)) u_alloc (
    .live(live_q), .pick(alloc_vec), .full(tbl_full));

  assign req_new    = req_valid && !req_hit;
  assign req_drop   = req_new && tbl_full;
  assign ack_orphan = ack_valid && !ack_hit;

  assign qry_valid = ack_valid;
  assign qry_seq   = ack_seq;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic opening;
    assign opening      = req_new && !tbl_full && alloc_vec[i];
    assign inc_vec[i]   = (req_valid && req_hit_vec[i]) || opening;
    assign dec_vec[i]   = ack_valid && ack_hit_vec[i];
    assign fin_vec[i]   = retire_cond(dec_vec[i], inc_vec[i],
                                      cnt_q[i] == CNT_ONE, qry_pending);
    assign under_vec[i] = under_cond(dec_vec[i], inc_vec[i], cnt_q[i] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q[i]                 <= 1'b0;
        seq_q[i*SEQ_W +: SEQ_W]   <= '0;
        cnt_q[i]                  <= '0;
        rid_q[i]                  <= '0;
      end else if (fin_vec[i]) begin
        live_q[i] <= 1'b0;
        cnt_q[i]  <= '0;
      end else if (opening) begin
        live_q[i]               <= 1'b1;
        seq_q[i*SEQ_W +: SEQ_W] <= req_seq;
        cnt_q[i]                <= CNT_ONE;
        rid_q[i]                <= req_rid;
      end else if (!under_vec[i]) begin
        cnt_q[i] <= cnt_next(cnt_q[i], inc_vec[i], dec_vec[i]);
      end
    end
  end

  always_comb begin
    fin_rid = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (fin_vec[i]) fin_rid = fin_rid | rid_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_seq   <= '0;
      done_rid   <= '0;
      err_sticky <= 1'b0;
    end else begin
      done_valid <= |fin_vec;
      if (|fin_vec) begin
        done_seq <= ack_seq;
        done_rid <= fin_rid;
      end
      if (ack_orphan || req_drop || (|under_vec)) err_sticky <= 1'b1;
    end
  end

endmodule

// File: rtl/store_done_tracker_chk.sv
module store_done_tracker_chk #(
  parameter int SEQ_W   = 16,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               ack_valid,
  input logic [SEQ_W-1:0]   ack_seq,
  input logic               qry_pending,
  input logic               done_valid,
  input logic [SEQ_W-1:0]   done_seq,
  input logic               err_sticky,
  input logic               ack_hit,
  input logic [ENTRIES-1:0] ack_hit_vec,
  input logic               req_new,
  input logic               tbl_full
);
  // R4: a pulse follows an acknowledgement of the same number
  p_done_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ($past(ack_valid) && $past(ack_seq) == done_seq));

  // R5: no completion while the coalescer still buffered packets
  p_done_needs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !$past(qry_pending));

  // R6: error flag never falls outside reset
  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  // R6: orphan acknowledgement raises the flag
  p_orphan_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_hit) |=> err_sticky);

  // R7: request dropped on a full table raises the flag
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_new && tbl_full) |=> err_sticky);

  // R2: a sequence number lives in at most one entry
  p_unique_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_hit_vec));
endmodule

bind store_done_tracker store_done_tracker_chk #(.SEQ_W(SEQ_W), .ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ack_valid(ack_valid),
  .ack_seq(ack_seq), .qry_pending(qry_pending), .done_valid(done_valid),
  .done_seq(done_seq), .err_sticky(err_sticky), .ack_hit(ack_hit),
  .ack_hit_vec(ack_hit_vec), .req_new(req_new), .tbl_full(tbl_full));

// File: tb/store_done_tracker_tb_top.sv
module store_done_tracker_tb_top;
  localparam int SEQ_W = 16;
  localparam int RID_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, ack_valid = 1'b0, qry_pending = 1'b0;
  logic [SEQ_W-1:0] req_seq = '0, ack_seq = '0;
  logic [RID_W-1:0] req_rid = '0;
  logic qry_valid, done_valid, err_sticky;
  logic [SEQ_W-1:0] qry_seq, done_seq;
  logic [RID_W-1:0] done_rid;

  int n_chk = 0, n_bad = 0;
  bit summary_done = 0;
  logic [SEQ_W+RID_W-1:0] expq [$];

  always #5 clk = ~clk;

  store_done_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seq(req_seq),
    .req_rid(req_rid), .ack_valid(ack_valid), .ack_seq(ack_seq),
    .qry_valid(qry_valid), .qry_seq(qry_seq), .qry_pending(qry_pending),
    .done_valid(done_valid), .done_seq(done_seq), .done_rid(done_rid),
    .err_sticky(err_sticky));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // driver: one cycle of stimulus, set at the falling edge
  task automatic cyc(input bit rv, input int rs, input int rr,
                     input bit av, input int as, input bit ap);
    @(negedge clk);
    req_valid = rv; req_seq = SEQ_W'(rs); req_rid = RID_W'(rr);
    ack_valid = av; ack_seq = SEQ_W'(as); qry_pending = ap;
    if (av) begin
      #1;
      check(qry_valid && qry_seq == SEQ_W'(as), "R8 query mirror", int'(qry_seq), as);
    end
  endtask

  task automatic req(input int s, input int r);
    cyc(1, s, r, 0, 0, 0);
  endtask
  task automatic ack(input int s, input bit busy);
    cyc(0, 0, 0, 1, s, busy);
  endtask
  task automatic ack_done(input int s, input int r);
    expq.push_back({SEQ_W'(s), RID_W'(r)});
    cyc(0, 0, 0, 1, s, 0);
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  // monitor: compares every pulse against the scoreboard (R4, R10)
  always @(negedge clk) begin
    if (rst_n && done_valid) begin
      if (expq.size() == 0) begin
        check(0, "R4/R5 unexpected completion", int'(done_seq), -1);
      end else begin
        logic [SEQ_W+RID_W-1:0] e;
        e = expq.pop_front();
        check(done_seq == e[RID_W +: SEQ_W], "R10 completion seq",
              int'(done_seq), int'(e[RID_W +: SEQ_W]));
        check(done_rid == e[RID_W-1:0], "R2 completion rid",
              int'(done_rid), int'(e[RID_W-1:0]));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!done_valid && !err_sticky, "R1 reset state", int'(done_valid) + int'(err_sticky), 0);

    // R3/R2: three requests, identity of the first kept
    req(10, 3); req(10, 7); req(10, 7);
    ack(10, 0); ack(10, 0);
    ack_done(10, 3);
    idle(2);
    // R4: entry freed, reopened with a fresh identity
    req(10, 5); ack_done(10, 5); idle(2);

    // R5: buffer busy on last ack holds the entry
    req(20, 1); ack(20, 1); idle(3);
    check(expq.size() == 0 && !err_sticky, "R5 held entry", expq.size(), 0);
    req(20, 9); ack_done(20, 1); idle(2);

    // R9: same-cycle request and acknowledgement
    req(30, 2);
    cyc(1, 30, 6, 1, 30, 0);
    idle(2);
    ack_done(30, 2); idle(2);

    // R10: interleaved instructions, completion order follows acks
    req(40, 4); req(41, 11); req(40, 4);
    ack(40, 0);
    ack_done(41, 11);
    ack_done(40, 4);
    idle(2);
    check(expq.size() == 0, "R10 all completions seen", expq.size(), 0);
    check(!err_sticky, "R6 no false error", int'(err_sticky), 0);

    // R6: orphan acknowledgement
    ack(99, 0); idle(1);
    check(err_sticky, "R6 orphan sets error", int'(err_sticky), 1);
    idle(3);
    check(err_sticky, "R6 error sticky", int'(err_sticky), 1);

    // R1 again after reset
    @(negedge clk); rst_n = 1'b0; idle(2); @(negedge clk); rst_n = 1'b1;
    check(!err_sticky && !done_valid, "R1 reset clears", int'(err_sticky), 0);

    // R7: table full drops a new number
    req(70, 1); req(71, 2); req(72, 3); req(73, 4); idle(1);
    check(!err_sticky, "R7 full table ok", int'(err_sticky), 0);
    req(80, 8); idle(1);
    check(err_sticky, "R7 drop sets error", int'(err_sticky), 1);
    ack(80, 0); idle(2);
    ack_done(72, 3); ack_done(70, 1); ack_done(73, 4); ack_done(71, 2);
    idle(3);
    check(expq.size() == 0, "R7 drained, dropped number never completes", expq.size(), 0);
    check(err_sticky, "R6 error still held", int'(err_sticky), 1);

    summary();
  end
endmodule